// File: doc/BRIEF.md
# Serial DAC Code Register Front End

This block is the digital front end of a multiplying DAC. It takes 16-bit frames from a three-wire serial link: an active-low frame strobe, a serial clock and a data line. It keeps a double-buffered output code. All three pins are sampled in a faster system-clock domain through two-flop synchronisers, and edge detectors turn them into events. While the strobe is low, the data line is shifted into an input register on the selected serial clock edge. When the strobe rises after a complete frame, the two leading control bits decide what happens: the data field goes to the DAC code register, the sampling edge changes, or nothing happens.

The data resolution is a parameter from 8 to 14 bits. The data field is left-justified directly below the control bits, and any trailing bits are ignored. A separate pulse marks every write of the code register so that downstream logic can follow updates.

Top module: `sdac_frame_rx`

## Requirements
- R1: After reset, `dac_code` is 0, `rise_mode` is 0 (falling-edge sampling) and `upd_pulse` is 0.
- R2: A frame is shifted MSB first. Frame bits 15:14 are the command. The code is taken from bits 13 down to 14-DATA_W, and lower bits have no effect on `dac_code`.
- R3: While `rise_mode` is 0, the data line is sampled on falling serial clock edges only.
- R4: Command 00 in a complete frame writes the data field to `dac_code` when the strobe rises, with a single-cycle `upd_pulse`.
- R5: Command 11 in a complete frame sets `rise_mode` to 1, and sampling then uses rising edges. Only reset clears `rise_mode`; later frames do not.
- R6: A command 11 frame leaves `dac_code` unchanged and gives no `upd_pulse`.
- R7: Commands 01 and 10 change neither `dac_code` nor `rise_mode`.
- R8: A frame with fewer than 16 active edges before the strobe rises is discarded.
- R9: Active edges after the 16th in one strobe-low window are ignored.
- R10: `dac_code` never changes while a frame is being shifted. It changes only after the strobe rises.
- R11: Serial clock edges while the strobe is high are ignored. Each strobe fall starts a new frame from bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low frame strobe |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data |
| dac_code | output | DATA_W | Current DAC code |
| rise_mode | output | 1 | 1 when sampling on rising serial clock edges |
| upd_pulse | output | 1 | One-cycle pulse on each code register write |

## Verification
The bench changes the data line between the rising and the falling serial clock edge of every bit, so the two edges see different values. A design that samples on the wrong edge then loads a visibly different code, both before and after the mode frame. Aborted frames that are followed by a full frame show whether a design loads partial data or keeps a stale bit count from the aborted frame. The mode frame and the reserved commands show whether a design writes the code or raises the pulse on a command that must leave the code alone. Over-long frames, and a reset after rising mode has been set, show whether extra bits shift the field and whether the edge setting stays set until reset clears it.

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              sck,
  input  logic              sdi,
  output logic [DATA_W-1:0] dac_code,
  output logic              rise_mode,
  output logic              upd_pulse
);
  localparam int FRAME_W = 16;
  localparam int KEEP_W  = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [2:0]        sync_p, sck_p;
  logic [1:0]        sdi_p;
  logic [KEEP_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;

  wire in_frame    = ~sync_p[1];
  wire frame_begin = sync_p[2] & ~sync_p[1];
  wire frame_end   = ~sync_p[2] & sync_p[1];
  wire sck_rise    = ~sck_p[2] & sck_p[1];
  wire sck_fall    = sck_p[2] & ~sck_p[1];
  wire take        = in_frame & (rise_mode ? sck_rise : sck_fall) &
                     (bit_cnt != CNT_W'(FRAME_W));
  wire complete    = bit_cnt == CNT_W'(FRAME_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_p <= '1;
      sck_p  <= '0;
      sdi_p  <= '0;
    end else begin
      sync_p <= {sync_p[1:0], frame_n};
      sck_p  <= {sck_p[1:0], sck};
      sdi_p  <= {sdi_p[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (frame_begin) begin
      bit_cnt <= '0;
    end else if (take) begin
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt < CNT_W'(KEEP_W))
        shreg <= {shreg[KEEP_W-2:0], sdi_p[1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code  <= '0;
      rise_mode <= 1'b0;
      upd_pulse <= 1'b0;
    end else begin
      upd_pulse <= 1'b0;
      if (frame_end && complete) begin
        case (shreg[KEEP_W-1 -: 2])
          2'b00: begin
            dac_code  <= shreg[DATA_W-1:0];
            upd_pulse <= 1'b1;
          end
          2'b11:   rise_mode <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  a_r10_code_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> $past(frame_end));
  a_r5_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rise_mode |=> rise_mode);
  a_r6_no_pulse_on_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rise_mode) |-> !upd_pulse);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> !upd_pulse);
  a_r8_pulse_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> $past(complete));
  a_r9_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == CNT_W'(FRAME_W) && !frame_begin) |=> bit_cnt == CNT_W'(FRAME_W));
endmodule

// File: tb/test_sdac_frame_rx.sv
`timescale 1ns/1ps
module test_sdac_frame_rx;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, frame_n = 1, sck = 0, sdi = 0;
  logic [W-1:0] dac_code;
  logic rise_mode, upd_pulse;
  int checks = 0, fails = 0, pulses_seen = 0, exp_pulses = 0;
  logic [W-1:0] exp_code = '0;
  logic exp_rise = 0, hold = 1;

  sdac_frame_rx #(.DATA_W(W)) i_sdac_frame_rx (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sck(sck), .sdi(sdi),
    .dac_code(dac_code), .rise_mode(rise_mode), .upd_pulse(upd_pulse));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && upd_pulse) pulses_seen++;
    if (rst_n && !hold) begin
      checks++;
      if (dac_code !== exp_code || rise_mode !== exp_rise) begin
        fails++;
        if (fails < 10)
          $display("FAIL R10 model actual=%0h/%0b expected=%0h/%0b",
                   dac_code, rise_mode, exp_code, exp_rise);
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [15:0] vr, input logic [15:0] vf, input int n);
    logic [15:0] cap;
    frame_n = 0; wclk(4);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 16) ? vr[15-i] : ~vr[0]; wclk(3); sck = 1; wclk(2);
      sdi = (i < 16) ? vf[15-i] : vf[0];  wclk(3); sck = 0; wclk(3);
    end
    wclk(2);
    chk("R10", {24'b0, dac_code}, {24'b0, exp_code});
    hold = 1; frame_n = 1; wclk(8);
    cap = exp_rise ? vr : vf;
    if (n >= 16) begin
      if (cap[15:14] == 2'b00) begin
        exp_code = cap[13 -: W];
        exp_pulses++;
      end else if (cap[15:14] == 2'b11) exp_rise = 1;
    end
    hold = 0; wclk(3);
    chk("R4 pulses", pulses_seen, exp_pulses);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wclk(3);
    chk("R1 code", dac_code, 0); chk("R1 mode", rise_mode, 0); chk("R1 pulse", upd_pulse, 0);
    rst_n = 1; wclk(2); hold = 0;

    send({2'b00, 8'hA5, 6'b101101}, {2'b00, 8'hA5, 6'b010010}, 16);
    chk("R2 load", dac_code, 8'hA5);
    send({2'b00, 8'h0F, 6'h00}, {2'b00, 8'h3C, 6'h3F}, 16);
    chk("R3 falling", dac_code, 8'h3C);
    send({2'b00, 8'h77, 6'h00}, {2'b00, 8'h77, 6'h00}, 10);
    chk("R8 short", dac_code, 8'h3C);

    sdi = 1;
    for (int k = 0; k < 4; k++) begin sck = 1; wclk(4); sck = 0; wclk(4); end
    send({2'b00, 8'h81, 6'h00}, {2'b00, 8'h81, 6'h00}, 16);
    chk("R11 fresh frame", dac_code, 8'h81);

    send({2'b01, 8'h11, 6'h00}, {2'b01, 8'h11, 6'h00}, 16);
    chk("R7 code01", dac_code, 8'h81);
    send({2'b10, 8'h22, 6'h00}, {2'b10, 8'h22, 6'h00}, 16);
    chk("R7 code10", dac_code, 8'h81); chk("R7 mode", rise_mode, 0);

    send({2'b00, 8'hEE, 6'h00}, {2'b11, 8'h55, 6'h00}, 16);
    chk("R5 mode set", rise_mode, 1); chk("R6 code kept", dac_code, 8'h81);

    send({2'b00, 8'hC3, 6'h00}, {2'b00, 8'h18, 6'h00}, 16);
    chk("R5 rising", dac_code, 8'hC3); chk("R5 sticky", rise_mode, 1);
    send({2'b11, 8'h99, 6'h00}, {2'b00, 8'h66, 6'h00}, 16);
    chk("R6 again", dac_code, 8'hC3); chk("R5 still", rise_mode, 1);

    send({2'b00, 8'h5A, 6'h15}, {2'b00, 8'h5A, 6'h15}, 20);
    chk("R9 extra", dac_code, 8'h5A);
    send({2'b00, 8'hFF, 6'h3F}, {2'b00, 8'hFF, 6'h3F}, 16);
    chk("R2 full", dac_code, 8'hFF);
    send({2'b00, 8'h00, 6'h3F}, {2'b00, 8'h00, 6'h3F}, 16);
    chk("R2 zero", dac_code, 8'h00);
    send({2'b00, 8'h42, 6'h00}, {2'b00, 8'h42, 6'h00}, 16);

    hold = 1; rst_n = 0; wclk(3);
    exp_code = '0; exp_rise = 0;
    chk("R1 code", dac_code, 0); chk("R1 mode", rise_mode, 0);
    rst_n = 1; wclk(2); hold = 0;
    send({2'b00, 8'h24, 6'h00}, {2'b00, 8'hB7, 6'h00}, 16);
    chk("R3 after reset", dac_code, 8'hB7);

    wclk(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule